// File: doc/BRIEF.md
# Event-Counting Performance Monitor

The block counts hardware events for profiling. One cycle counter runs from the clock. Four event counters each follow one strobe from a vector of one-cycle event pulses. An 8-bit selector field per counter picks which strobe that counter follows. All counters are 32 bits wide and writable. To make a counter wrap after N events, software loads it with the two's complement of N. When it wraps, a sticky overflow flag is set. Each flag can raise a level interrupt if its enable bit is set.

Software reaches the block through a single-cycle register port. A write takes effect at the clock edge and a read is combinational on the address. The word offsets are:

| Offset | Register |
|---|---|
| 0 | Control |
| 1 | Interrupt enable |
| 2 | Overflow flags |
| 3 | Packed selectors |
| 4 | Cycle counter |
| 5 to 8 | Event counters 0 to 3 |

Any other offset reads as zero. In the control register:

| Bit | Function |
|---|---|
| 0 | Run |
| 1 | Clear all event counters (action, write 1) |
| 2 | Clear the cycle counter and its prescaler (action, write 1) |
| 3 | Divide the cycle counter by 64 |

The flag and enable registers use the same bit positions: bit 0 is the cycle counter and bit k+1 is event counter k.

Top module: `perf_mon`

## Requirements
- R1: After reset, every register reads zero and `irq` is low.
- R2: Control keeps only bit 0 (run) and bit 3 (divide). Bits 1 and 2 act only when written as 1 and read back as 0. Bits 31:4 read as zero and writes to them do nothing.
- R3: While the run bit is 0, no counter changes except by a register write or a clear bit. Reads and writes still work.
- R4: Event counter k adds one on each clock edge where run is 1 and the strobe named by selector bits 8k+7:8k is high. It adds at most one per clock. The selector register reads back as written.
- R5: A selector code of 0xFF, or any code at or above the number of strobe inputs, makes its counter count nothing.
- R6: With run set and divide clear, the cycle counter adds one per clock. With divide set, it adds one on every 64th running clock.
- R7: Writing control bit 1 as 1 zeroes all event counters and leaves the cycle counter alone. Writing bit 2 as 1 zeroes the cycle counter and the prescaler.
- R8: A write to a counter loads the written value. If an increment falls in the same cycle, the write wins.
- R9: A counter that steps from 0xFFFFFFFF to 0 sets its overflow flag at that same edge. Flag bit 0 belongs to the cycle counter and bit k+1 to event counter k.
- R10: Writing 1 to a flag bit clears that flag. Writing 0 leaves it unchanged. If a wrap and a clear hit the same flag in one cycle, the flag stays set.
- R11: `irq` is the registered OR of the flags ANDed with the enables, using the same bit positions. It follows a change one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| evt_strobe | input | 32 | One-cycle event pulses, indexed by selector code |
| irq | output | 1 | Level interrupt |

## Verification
The hardest case to reach is a wrap and a write-one clear landing on the same flag in the same cycle. To get there, the bench loads a counter to all ones while the block is stopped. It then sets run, and in one cycle raises the selected strobe and writes the clear mask. After that it reads the flag register back to confirm the flag survived. The divide-by-64 boundary is reached by running exactly 63 clocks, checking that the counter has not moved, and then running one more.

// File: rtl/perf_mon_pkg.sv
package perf_mon_pkg;
  // Register word offsets
  localparam int PM_A_CTRL = 0;
  localparam int PM_A_IEN  = 1;
  localparam int PM_A_FLAG = 2;
  localparam int PM_A_SEL  = 3;
  localparam int PM_A_CYC  = 4;
  localparam int PM_A_EVT0 = 5;
  // Control bit positions
  localparam int PM_C_RUN     = 0;
  localparam int PM_C_CLR_EVT = 1;
  localparam int PM_C_CLR_CYC = 2;
  localparam int PM_C_DIV     = 3;
endpackage

// File: rtl/pm_counter.sv
module pm_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  function automatic logic at_top(input logic [W-1:0] v);
    return &v;
  endfunction

  function automatic logic [W-1:0] bump(input logic [W-1:0] v);
    return v + W'(1);
  endfunction

  // Only a real increment wraps; a load or clear in the same cycle wins
  assign wrap = inc && !ld && !clr && at_top(cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (ld)    cnt <= ld_val;
    else if (clr)   cnt <= '0;
    else if (inc)   cnt <= bump(cnt);
  end
endmodule

// File: rtl/pm_prescale.sv
module pm_prescale #(
  parameter int DIV = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q;

  assign tick = run && (pre_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pre_q <= '0;
    else if (clr)   pre_q <= '0;
    else if (tick)  pre_q <= '0;
    else if (run)   pre_q <= pre_q + PW'(1);
  end
endmodule

// File: rtl/pm_evt_sel.sv
module pm_evt_sel #(
  parameter int NUM_SRC = 32,
  parameter int SEL_W   = 8
) (
  input  logic [NUM_SRC-1:0] strobes,
  input  logic [SEL_W-1:0]   sel,
  output logic               hit
);
  // Codes without a matching strobe (including the unused code) never hit
  function automatic logic pick(input logic [NUM_SRC-1:0] s, input logic [SEL_W-1:0] c);
    logic r;
    r = 1'b0;
    for (int i = 0; i < NUM_SRC; i++)
      if (c == SEL_W'(i)) r = s[i];
    return r;
  endfunction

  assign hit = pick(strobes, sel);
endmodule

// File: rtl/pm_flags.sv
module pm_flags #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic         clr_wr,
  input  logic [N-1:0] clr_mask,
  input  logic [N-1:0] ien,
  output logic [N-1:0] flags,
  output logic         irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      irq   <= 1'b0;
    end else begin
      flags <= (flags & ~(clr_wr ? clr_mask : '0)) | set_vec;
      irq   <= |(flags & ien);
    end
  end
endmodule

// File: rtl/perf_mon.sv
module perf_mon
  import perf_mon_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int NUM_EVT  = 4,
  parameter int SEL_W    = 8,
  parameter int NUM_SRC  = 32,
  parameter int PRESCALE = 64,
  parameter int ADDR_W   = $clog2(PM_A_EVT0 + NUM_EVT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [CNT_W-1:0]   reg_wdata,
  output logic [CNT_W-1:0]   reg_rdata,
  input  logic [NUM_SRC-1:0] evt_strobe,
  output logic               irq
);
  localparam int NCTR   = NUM_EVT + 1;
  localparam int SELR_W = NUM_EVT * SEL_W;
  localparam logic [ADDR_W-1:0] AD_CTRL = ADDR_W'(PM_A_CTRL);
  localparam logic [ADDR_W-1:0] AD_IEN  = ADDR_W'(PM_A_IEN);
  localparam logic [ADDR_W-1:0] AD_FLAG = ADDR_W'(PM_A_FLAG);
  localparam logic [ADDR_W-1:0] AD_SEL  = ADDR_W'(PM_A_SEL);
  localparam logic [ADDR_W-1:0] AD_CYC  = ADDR_W'(PM_A_CYC);

  logic               en_q, div_q;
  logic [NCTR-1:0]    ien_q;
  logic [SELR_W-1:0]  sel_q;
  logic [NCTR-1:0]    ovf_q;
  logic [NCTR-1:0]    wrap_vec;
  logic [NCTR*CNT_W-1:0] cnt_all;

  // Named write events
  logic wr_ctrl, wr_ien, wr_flag, wr_sel, wr_cyc;
  logic clr_evt, clr_cyc;
  logic pre_tick, cyc_inc;

  assign wr_ctrl = reg_wr && (reg_addr == AD_CTRL);
  assign wr_ien  = reg_wr && (reg_addr == AD_IEN);
  assign wr_flag = reg_wr && (reg_addr == AD_FLAG);
  assign wr_sel  = reg_wr && (reg_addr == AD_SEL);
  assign wr_cyc  = reg_wr && (reg_addr == AD_CYC);
  assign clr_evt = wr_ctrl && reg_wdata[PM_C_CLR_EVT];
  assign clr_cyc = wr_ctrl && reg_wdata[PM_C_CLR_CYC];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      div_q <= 1'b0;
      ien_q <= '0;
      sel_q <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q  <= reg_wdata[PM_C_RUN];
        div_q <= reg_wdata[PM_C_DIV];
      end
      if (wr_ien) ien_q <= reg_wdata[NCTR-1:0];
      if (wr_sel) sel_q <= reg_wdata[SELR_W-1:0];
    end
  end

  // Cycle counter with optional prescale
  pm_prescale #(.DIV(PRESCALE)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(clr_cyc), .run(en_q && div_q), .tick(pre_tick)
  );

  assign cyc_inc = en_q && (!div_q || pre_tick);

  pm_counter #(.W(CNT_W)) u_cyc (
    .clk(clk), .rst_n(rst_n), .clr(clr_cyc), .ld(wr_cyc), .ld_val(reg_wdata),
    .inc(cyc_inc), .cnt(cnt_all[CNT_W-1:0]), .wrap(wrap_vec[0])
  );

  // Event counters
  for (genvar k = 0; k < NUM_EVT; k++) begin : g_evt
    logic hit;
    logic wr_me;
    assign wr_me = reg_wr && (reg_addr == ADDR_W'(PM_A_EVT0 + k));

    pm_evt_sel #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_sel (
      .strobes(evt_strobe), .sel(sel_q[k*SEL_W +: SEL_W]), .hit(hit)
    );

    pm_counter #(.W(CNT_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .clr(clr_evt), .ld(wr_me), .ld_val(reg_wdata),
      .inc(en_q && hit), .cnt(cnt_all[(k+1)*CNT_W +: CNT_W]), .wrap(wrap_vec[k+1])
    );
  end

  pm_flags #(.N(NCTR)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_vec(wrap_vec), .clr_wr(wr_flag),
    .clr_mask(reg_wdata[NCTR-1:0]), .ien(ien_q), .flags(ovf_q), .irq(irq)
  );

  // Read mux
  always_comb begin
    reg_rdata = '0;
    if (reg_addr == AD_CTRL) begin
      reg_rdata[PM_C_RUN] = en_q;
      reg_rdata[PM_C_DIV] = div_q;
    end else if (reg_addr == AD_IEN) begin
      reg_rdata = CNT_W'(ien_q);
    end else if (reg_addr == AD_FLAG) begin
      reg_rdata = CNT_W'(ovf_q);
    end else if (reg_addr == AD_SEL) begin
      reg_rdata = CNT_W'(sel_q);
    end else begin
      for (int i = 0; i < NCTR; i++)
        if (reg_addr == ADDR_W'(PM_A_CYC + i)) reg_rdata = cnt_all[i*CNT_W +: CNT_W];
    end
  end
endmodule

// File: rtl/perf_mon_chk.sv
module perf_mon_chk
  import perf_mon_pkg::*;
#(
  parameter int N      = 5,
  parameter int W      = 32,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [N-1:0]      wd_lo,
  input logic [W-1:0]      reg_rdata,
  input logic [N-1:0]      ovf_q,
  input logic [N-1:0]      ien_q,
  input logic              irq,
  input logic [N-1:0]      wrap_vec,
  input logic              en_q,
  input logic [N*W-1:0]    cnt_all
);
  logic [N-1:0] clr_m;
  logic [N-1:0] keep;
  assign clr_m = (reg_wr && reg_addr == ADDR_W'(PM_A_FLAG)) ? wd_lo : '0;
  assign keep  = ovf_q & ~clr_m;

  // R11: interrupt lags the masked flags by one clock
  p_irq_lag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(|(ovf_q & ien_q))));

  // R9: a wrap leaves its flag set at the next sample
  p_wrap_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|wrap_vec) |=> ((ovf_q & $past(wrap_vec)) == $past(wrap_vec)));

  // R10: flags not cleared by a write stay set
  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(keep) & ~ovf_q) == '0));

  // R3: stopped and no write means frozen counters
  p_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !reg_wr) |=> $stable(cnt_all));

  // R2: control reads only run and divide
  p_ctrl_rsvd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(PM_A_CTRL)) |-> ((reg_rdata & ~W'(9)) == '0));

  // R4: without writes, a counter moves by at most one
  for (genvar i = 0; i < N; i++) begin : g_step
    p_step_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_wr |=> (cnt_all[i*W +: W] == $past(cnt_all[i*W +: W]) ||
                   cnt_all[i*W +: W] == $past(cnt_all[i*W +: W]) + W'(1)));
  end
endmodule

bind perf_mon perf_mon_chk #(.N(NCTR), .W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .wd_lo(reg_wdata[NCTR-1:0]), .reg_rdata(reg_rdata), .ovf_q(ovf_q),
  .ien_q(ien_q), .irq(irq), .wrap_vec(wrap_vec), .en_q(en_q), .cnt_all(cnt_all)
);

// File: tb/perf_mon_tb_top.sv
module perf_mon_tb_top;
  localparam int A_CTRL = 0, A_IEN = 1, A_FLAG = 2, A_SEL = 3, A_CYC = 4, A_EVT0 = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  drv_addr = '0;
  logic [3:0]  mon_addr = '0;
  logic        mon_busy = 1'b0;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] evt_strobe = '0;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  int req_cnt = 0;
  int ack_cnt = 0;
  bit finished = 0;

  typedef struct {
    logic [3:0]  addr;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t exp_q[$];

  always #5 clk = ~clk;
  assign reg_addr = mon_busy ? mon_addr : drv_addr;

  perf_mon dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_strobe(evt_strobe), .irq(irq)
  );

  // Monitor: pops expected reads and compares
  initial begin
    forever begin
      wait (ack_cnt != req_cnt);
      mon_addr = exp_q[0].addr;
      mon_busy = 1'b1;
      #1;
      n_chk++;
      if (reg_rdata !== exp_q[0].exp) begin
        n_fail++;
        $display("FAIL %s: addr %0d actual %h expected %h",
                 exp_q[0].tag, exp_q[0].addr, reg_rdata, exp_q[0].exp);
      end
      mon_busy = 1'b0;
      void'(exp_q.pop_front());
      ack_cnt++;
    end
  end

  task automatic expect_rd(input int a, input logic [31:0] e, input string tag);
    item_t it;
    it.addr = 4'(a); it.exp = e; it.tag = tag;
    exp_q.push_back(it);
    req_cnt++;
    wait (ack_cnt == req_cnt);
  endtask

  task automatic chk_irq(input logic e, input string tag);
    n_chk++;
    if (irq !== e) begin
      n_fail++;
      $display("FAIL %s: irq actual %b expected %b", tag, irq, e);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    drv_addr = 4'(a); reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic pulse(input logic [31:0] m);
    evt_strobe = m;
    @(posedge clk); @(negedge clk);
    evt_strobe = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 9; a++) expect_rd(a, 32'h0, "R1 reset value");
    chk_irq(1'b0, "R1 irq after reset");

    // R2: control keeps only run and divide
    wr(A_CTRL, 32'hFFFF_FFFF);
    expect_rd(A_CTRL, 32'h9, "R2 control readback");
    wr(A_CTRL, 32'h0);
    expect_rd(A_CTRL, 32'h0, "R2 control cleared");
    wr(A_CTRL, 32'h6);

    // R4/R5: selector fields, 0xFF unused
    wr(A_SEL, 32'hFF14_0703);
    expect_rd(A_SEL, 32'hFF14_0703, "R4 selector readback");
    wr(A_EVT0 + 3, 32'h55);
    wr(A_CTRL, 32'h4);
    wr(A_CTRL, 32'h1);
    pulse(32'h0000_0088);
    pulse(32'h0010_0009);
    pulse(32'hFFFF_FFFF);
    pulse(32'h0010_0000);
    wr(A_CTRL, 32'h0);
    expect_rd(A_EVT0 + 0, 32'd3, "R4 counter0 source 3");
    expect_rd(A_EVT0 + 1, 32'd2, "R4 counter1 source 7");
    expect_rd(A_EVT0 + 2, 32'd3, "R4 counter2 source 20");
    expect_rd(A_EVT0 + 3, 32'h55, "R5 unused selector");
    expect_rd(A_CYC, 32'd5, "R6 cycle count per clock");

    // R3: stopped block does not count
    pulse(32'hFFFF_FFFF); pulse(32'hFFFF_FFFF); idle(5);
    expect_rd(A_EVT0 + 0, 32'd3, "R3 event frozen");
    expect_rd(A_CYC, 32'd5, "R3 cycle frozen");

    // R7: clear bits
    wr(A_CTRL, 32'h2);
    expect_rd(A_EVT0 + 2, 32'd0, "R7 event clear");
    expect_rd(A_CYC, 32'd5, "R7 cycle kept");
    wr(A_CTRL, 32'h4);
    expect_rd(A_CYC, 32'd0, "R7 cycle clear");

    // R6: plain run of 10 clocks
    wr(A_CTRL, 32'h1); idle(9); wr(A_CTRL, 32'h0);
    expect_rd(A_CYC, 32'd10, "R6 ten clocks");

    // R6: divide by 64, boundary at the 64th running clock
    wr(A_CTRL, 32'h4);
    wr(A_CTRL, 32'h9); idle(62); wr(A_CTRL, 32'h0);
    expect_rd(A_CYC, 32'd0, "R6 divide 63 clocks");
    wr(A_CTRL, 32'h9); wr(A_CTRL, 32'h0);
    expect_rd(A_CYC, 32'd1, "R6 divide 64th clock");

    // R8: write beats increment in the same cycle
    wr(A_CTRL, 32'h1);
    evt_strobe = 32'h0010_0000;
    wr(A_EVT0 + 2, 32'd100);
    evt_strobe = '0;
    wr(A_CTRL, 32'h0);
    expect_rd(A_EVT0 + 2, 32'd100, "R8 write priority");

    // R9: wraps set flags
    wr(A_CTRL, 32'h6);
    wr(A_EVT0 + 0, 32'hFFFF_FFFE);
    wr(A_CYC, 32'hFFFF_FFFF);
    wr(A_CTRL, 32'h1);
    pulse(32'h8); pulse(32'h8);
    wr(A_CTRL, 32'h0);
    expect_rd(A_EVT0 + 0, 32'd0, "R9 counter0 wrapped");
    expect_rd(A_CYC, 32'd2, "R9 cycle wrapped");
    expect_rd(A_FLAG, 32'h3, "R9 flag positions");
    chk_irq(1'b0, "R11 masked flags");

    // R11: enable raises irq one clock later
    wr(A_IEN, 32'h2);
    chk_irq(1'b0, "R11 irq lag");
    idle(1);
    chk_irq(1'b1, "R11 irq raised");

    // R10: write-one-to-clear
    wr(A_FLAG, 32'h0);
    expect_rd(A_FLAG, 32'h3, "R10 zero write");
    wr(A_FLAG, 32'h1);
    expect_rd(A_FLAG, 32'h2, "R10 clear bit0");
    chk_irq(1'b1, "R11 irq held");

    // R10: wrap and clear in the same cycle
    wr(A_EVT0 + 0, 32'hFFFF_FFFF);
    wr(A_CTRL, 32'h1);
    evt_strobe = 32'h8;
    wr(A_FLAG, 32'h2);
    evt_strobe = '0;
    wr(A_CTRL, 32'h0);
    expect_rd(A_FLAG, 32'h2, "R10 set wins over clear");
    expect_rd(A_EVT0 + 0, 32'd0, "R9 counter0 second wrap");

    wr(A_FLAG, 32'h2);
    expect_rd(A_FLAG, 32'h0, "R10 cleared");
    chk_irq(1'b1, "R11 irq fall lag");
    idle(1);
    chk_irq(1'b0, "R11 irq fallen");

    finish_run();
  end
endmodule